// File: doc/BRIEF.md
# GPIO Interrupt Sense and Event Capture

This block turns the already-synchronised levels of a GPIO port into interrupt events. Every clock it compares each pin's level with the one it sampled on the previous clock. A rising or falling transition that matches the pin's programmed sense mode sets a sticky event bit. Software reads the pending events, clears them by writing ones, and enables pins through a mask. A single interrupt line is raised whenever any enabled event is pending. The number of the most urgent pending pin is also output, so the handler does not have to scan the word itself.

Two sense schemes exist, chosen by the `EXT_MODE` parameter. In the basic scheme each pin has one bit, selecting falling edge only or both edges. In the extended scheme each pin has a two-bit field, spread across two sense words, selecting both edges, rising only or falling only. A small sequencer with two states keeps the first clock after reset from reporting false edges. In `ST_PRIME` the previous-level register is loaded and detection is off. The transition `prime_done` moves it unconditionally to `ST_RUN` on the next clock. It stays in `ST_RUN`, with detection on, until reset returns it to `ST_PRIME`.

Top module: `gpio_evt_sense`

## Requirements
- R1: After reset the event, mask and both sense words read 0, and `irq_out` and `irq_pin_valid` are 0.
- R2: The registers sit at these byte offsets: events 0x0C, mask 0x10, sense word A 0x14, sense word B 0x18. Any other offset reads 0 and ignores writes. Pin n maps to bit (31 - n) of the event and mask words.
- R3: A write to the event word clears each bit written as 1 and leaves each bit written as 0 unchanged. Event bits stay set until cleared this way.
- R4: If a matching edge occurs on the same clock as a write that clears the pin's event bit, the bit ends up set.
- R5: `irq_out` is 1 exactly when the AND of the event and mask words is nonzero. Events are latched while masked, and setting the mask bit raises `irq_out` after that write's clock edge.
- R6: When `irq_out` is 1, `irq_pin_valid` is 1 and `irq_pin_id` gives the lowest-numbered pin that has both its event bit and its mask bit set.
- R7: In basic mode (`EXT_MODE`=0), bit (31 - n) of sense word A set to 1 makes pin n latch on falling edges only. Set to 0, it latches on both edges.
- R8: In extended mode (`EXT_MODE`=1), pin n has a 2-bit field at bits [(15 - n mod 16)*2 +: 2]. Pins 0-15 use sense word A and pins 16-31 use sense word B. Code 00 selects both edges, 01 selects rising only and 10 selects falling only.
- R9: In extended mode, sense code 11 never sets an event bit.
- R10: In basic mode, sense word B reads 0 and ignores writes.
- R11: Pin levels present when reset is released are not treated as edges. No event is set on the first clock after reset (state `ST_PRIME`).
- R12: An edge is seen when the level sampled at a clock edge differs from the level sampled at the one before. The event bit is readable after that same clock edge. A sense write made at that clock edge only applies to edges detected at later clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_lvl | input | NPINS (32) | Synchronised pin levels, bit n is pin n |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte offset for read and write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_out | output | 1 | Combined interrupt |
| irq_pin_valid | output | 1 | A pending, enabled pin exists |
| irq_pin_id | output | $clog2(NPINS) (5) | Lowest-numbered pending, enabled pin |

## Verification
The bench builds two instances with the full 32 pins. One uses `EXT_MODE`=1 and one uses `EXT_MODE`=0, and both are driven by the same pins and bus. The extended instance makes it possible to reach two-bit fields in both sense words, the reserved code and a sense change in the same clock as an edge. The basic instance covers the one-bit falling and both-edge modes and the absent second sense word. A second reset with all pins high checks the priming clock.

// File: rtl/gpio_evt_pkg.sv
package gpio_evt_pkg;

    localparam int unsigned WORD_W = 32;
    localparam int unsigned ADDR_W = 8;
    localparam int unsigned FIELDS = WORD_W / 2;

    localparam logic [ADDR_W-1:0] OFS_EVT = 8'h0C;
    localparam logic [ADDR_W-1:0] OFS_MSK = 8'h10;
    localparam logic [ADDR_W-1:0] OFS_SNA = 8'h14;
    localparam logic [ADDR_W-1:0] OFS_SNB = 8'h18;

    typedef enum logic [1:0] {
        SNS_BOTH = 2'b00,
        SNS_RISE = 2'b01,
        SNS_FALL = 2'b10,
        SNS_RSVD = 2'b11
    } sense_e;

    typedef enum logic {
        ST_PRIME = 1'b0,
        ST_RUN   = 1'b1
    } phase_e;

    // Bits of the event/mask word that belong to existing pins.
    function automatic logic [WORD_W-1:0] pin_bits(int unsigned npins);
        logic [WORD_W-1:0] m;
        m = '0;
        for (int n = 0; n < WORD_W; n++) begin
            if (n < int'(npins)) m[WORD_W-1-n] = 1'b1;
        end
        return m;
    endfunction

    // Writable bits of a sense word; word_sel 0 = A, 1 = B.
    function automatic logic [WORD_W-1:0] sense_bits(int unsigned npins, bit ext, bit word_sel);
        logic [WORD_W-1:0] m;
        m = '0;
        if (!ext) begin
            if (!word_sel) m = pin_bits(npins);
        end else begin
            for (int n = 0; n < WORD_W; n++) begin
                if (n < int'(npins) && ((n >= int'(FIELDS)) == word_sel)) begin
                    m[(FIELDS-1-(n % FIELDS))*2]     = 1'b1;
                    m[(FIELDS-1-(n % FIELDS))*2 + 1] = 1'b1;
                end
            end
        end
        return m;
    endfunction

endpackage

// File: rtl/gpio_evt_regs.sv
module gpio_evt_regs
    import gpio_evt_pkg::*;
#(
    parameter int unsigned NPINS    = 32,
    parameter bit          EXT_MODE = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [WORD_W-1:0] bus_wdata,
    input  logic [WORD_W-1:0] evt_q,
    output logic [WORD_W-1:0] bus_rdata,
    output logic [WORD_W-1:0] w1c_vec,
    output logic [WORD_W-1:0] mask_q,
    output logic [WORD_W-1:0] sense_a_q,
    output logic [WORD_W-1:0] sense_b_q
);

    localparam logic [WORD_W-1:0] PIN_M = pin_bits(NPINS);
    localparam logic [WORD_W-1:0] SNA_M = sense_bits(NPINS, EXT_MODE, 1'b0);
    localparam logic [WORD_W-1:0] SNB_M = sense_bits(NPINS, EXT_MODE, 1'b1);

    logic wr_msk, wr_sna, wr_snb;

    assign wr_msk  = bus_wr && (bus_addr == OFS_MSK);
    assign wr_sna  = bus_wr && (bus_addr == OFS_SNA);
    assign wr_snb  = bus_wr && (bus_addr == OFS_SNB);
    assign w1c_vec = (bus_wr && (bus_addr == OFS_EVT)) ? (bus_wdata & PIN_M) : '0;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q    <= '0;
            sense_a_q <= '0;
            sense_b_q <= '0;
        end else begin
            if (wr_msk) mask_q    <= bus_wdata & PIN_M;
            if (wr_sna) sense_a_q <= bus_wdata & SNA_M;
            if (wr_snb) sense_b_q <= bus_wdata & SNB_M;
        end
    end

    always_comb begin
        unique case (bus_addr)
            OFS_EVT: bus_rdata = evt_q;
            OFS_MSK: bus_rdata = mask_q;
            OFS_SNA: bus_rdata = sense_a_q;
            OFS_SNB: bus_rdata = sense_b_q;
            default: bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/gpio_evt_detect.sv
module gpio_evt_detect
    import gpio_evt_pkg::*;
#(
    parameter int unsigned NPINS    = 32,
    parameter bit          EXT_MODE = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NPINS-1:0]  pin_lvl,
    input  logic              detect_en,
    input  logic [WORD_W-1:0] sense_a,
    input  logic [WORD_W-1:0] sense_b,
    output logic [WORD_W-1:0] hit_vec
);

    logic [NPINS-1:0] prev_q;
    logic             unused_sense;

    assign unused_sense = ^{sense_a, sense_b};

    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= pin_lvl;
    end

    for (genvar n = 0; n < int'(NPINS); n++) begin : g_pin
        localparam int RB = WORD_W - 1 - n;
        localparam int FS = (FIELDS - 1 - (n % FIELDS)) * 2;
        sense_e code;
        logic   rise, fall, sel;

        if (EXT_MODE) begin : g_ext
            if (n < int'(FIELDS)) begin : g_lo
                assign code = sense_e'(sense_a[FS +: 2]);
            end else begin : g_hi
                assign code = sense_e'(sense_b[FS +: 2]);
            end
        end else begin : g_basic
            assign code = sense_a[RB] ? SNS_FALL : SNS_BOTH;
        end

        assign rise = pin_lvl[n] & ~prev_q[n];
        assign fall = ~pin_lvl[n] & prev_q[n];

        always_comb begin
            unique case (code)
                SNS_BOTH: sel = rise | fall;
                SNS_RISE: sel = rise;
                SNS_FALL: sel = fall;
                default:  sel = 1'b0;
            endcase
        end

        assign hit_vec[RB] = detect_en & sel;
    end

    for (genvar b = 0; b < int'(WORD_W - NPINS); b++) begin : g_nopin
        assign hit_vec[b] = 1'b0;
    end

endmodule

// File: rtl/gpio_evt_prio.sv
module gpio_evt_prio
    import gpio_evt_pkg::*;
#(
    parameter int unsigned NPINS = 32,
    localparam int unsigned IDW  = $clog2(NPINS)
) (
    input  logic [WORD_W-1:0] pend,
    output logic              valid,
    output logic [IDW-1:0]    id
);

    always_comb begin
        valid = 1'b0;
        id    = '0;
        for (int n = int'(NPINS) - 1; n >= 0; n--) begin
            if (pend[WORD_W-1-n]) begin
                valid = 1'b1;
                id    = IDW'(n);
            end
        end
    end

endmodule

// File: rtl/gpio_evt_sense.sv
module gpio_evt_sense
    import gpio_evt_pkg::*;
#(
    parameter int unsigned NPINS    = 32,
    parameter bit          EXT_MODE = 1'b1,
    localparam int unsigned IDW     = $clog2(NPINS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NPINS-1:0]  pin_lvl,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    output logic              irq_out,
    output logic              irq_pin_valid,
    output logic [IDW-1:0]    irq_pin_id
);

    phase_e            state_q, state_d;
    logic              detect_en;
    logic [WORD_W-1:0] evt_q, w1c_vec, hit_vec, mask_q, sense_a_q, sense_b_q, pend;

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_PRIME;
        else        state_q <= state_d;
    end

    // Next state: prime_done after one clock, then hold.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_PRIME: state_d = ST_RUN;
            ST_RUN:   state_d = ST_RUN;
            default:  state_d = ST_PRIME;
        endcase
    end

    // Outputs of the sequencer.
    always_comb begin
        unique case (state_q)
            ST_PRIME: detect_en = 1'b0;
            ST_RUN:   detect_en = 1'b1;
            default:  detect_en = 1'b0;
        endcase
    end

    gpio_evt_regs #(.NPINS(NPINS), .EXT_MODE(EXT_MODE)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .evt_q     (evt_q),
        .bus_rdata (bus_rdata),
        .w1c_vec   (w1c_vec),
        .mask_q    (mask_q),
        .sense_a_q (sense_a_q),
        .sense_b_q (sense_b_q)
    );

    gpio_evt_detect #(.NPINS(NPINS), .EXT_MODE(EXT_MODE)) u_det (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_lvl   (pin_lvl),
        .detect_en (detect_en),
        .sense_a   (sense_a_q),
        .sense_b   (sense_b_q),
        .hit_vec   (hit_vec)
    );

    // Sticky events: a new hit outranks a clear in the same clock.
    always_ff @(posedge clk) begin
        if (!rst_n) evt_q <= '0;
        else        evt_q <= (evt_q & ~w1c_vec) | hit_vec;
    end

    assign pend    = evt_q & mask_q;
    assign irq_out = |pend;

    gpio_evt_prio #(.NPINS(NPINS)) u_prio (
        .pend  (pend),
        .valid (irq_pin_valid),
        .id    (irq_pin_id)
    );

endmodule

// File: rtl/gpio_evt_sense_chk.sv
module gpio_evt_sense_chk
    import gpio_evt_pkg::*;
#(
    parameter int unsigned NPINS    = 32,
    parameter bit          EXT_MODE = 1'b1,
    localparam int unsigned IDW     = $clog2(NPINS)
) (
    input logic              clk,
    input logic              rst_n,
    input logic [WORD_W-1:0] evt_q,
    input logic [WORD_W-1:0] mask_q,
    input logic [WORD_W-1:0] w1c_vec,
    input logic [WORD_W-1:0] sense_a_q,
    input logic [WORD_W-1:0] sense_b_q,
    input phase_e            state_q,
    input logic              irq_out,
    input logic              irq_pin_valid,
    input logic [IDW-1:0]    irq_pin_id
);

    logic [WORD_W-1:0] pend, rsv_vec;
    logic              unused_chk;

    assign pend       = evt_q & mask_q;
    assign unused_chk = ^{sense_a_q, sense_b_q};

    for (genvar n = 0; n < int'(WORD_W); n++) begin : g_rsv
        localparam int FS = (FIELDS - 1 - (n % FIELDS)) * 2;
        if (EXT_MODE && n < int'(NPINS)) begin : g_on
            if (n < int'(FIELDS)) begin : g_lo
                assign rsv_vec[WORD_W-1-n] = &sense_a_q[FS +: 2];
            end else begin : g_hi
                assign rsv_vec[WORD_W-1-n] = &sense_b_q[FS +: 2];
            end
        end else begin : g_off
            assign rsv_vec[WORD_W-1-n] = 1'b0;
        end
    end

    p_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (((($past(evt_q) & ~$past(w1c_vec)) & ~evt_q)) == '0));

    p_irq_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out == irq_pin_valid);

    p_prio_r6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pin_valid |-> (pend[WORD_W-1-int'(irq_pin_id)]
                           && ((pend >> (WORD_W - int'(irq_pin_id))) == '0)));

    p_reserved_r9: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((evt_q & ~$past(evt_q) & $past(rsv_vec)) == '0));

    p_prime_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PRIME) |=> ((evt_q & ~$past(evt_q)) == '0));

endmodule

bind gpio_evt_sense gpio_evt_sense_chk #(.NPINS(NPINS), .EXT_MODE(EXT_MODE)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .evt_q         (evt_q),
    .mask_q        (mask_q),
    .w1c_vec       (w1c_vec),
    .sense_a_q     (sense_a_q),
    .sense_b_q     (sense_b_q),
    .state_q       (state_q),
    .irq_out       (irq_out),
    .irq_pin_valid (irq_pin_valid),
    .irq_pin_id    (irq_pin_id)
);

// File: tb/gpio_evt_sense_bench.sv
module gpio_evt_sense_bench;
    import gpio_evt_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int WD_CYCLES  = 5000;
    localparam int NVEC       = 16;

    typedef struct packed {
        logic [31:0] pins;
        logic        wr;
        logic [7:0]  addr;
        logic [31:0] wdata;
        logic [31:0] exp_evt;
        logic        exp_irq;
        logic [4:0]  exp_id;
        logic [3:0]  req;
    } vec_t;

    // Extended-mode instance walk. Each row: drive, one clock, read events.
    localparam vec_t TBL [NVEC] = '{
        '{32'h0000_0001, 1'b0, OFS_EVT, 32'h0,         32'h8000_0000, 1'b0, 5'd0,  4'd8},  // R8 code 00 rise
        '{32'h0000_0001, 1'b1, OFS_MSK, 32'hFFFF_FFFF, 32'h8000_0000, 1'b1, 5'd0,  4'd5},  // R5 late enable
        '{32'h0000_0003, 1'b0, OFS_EVT, 32'h0,         32'hC000_0000, 1'b1, 5'd0,  4'd6},  // R6 pin0 wins
        '{32'h0000_0003, 1'b1, OFS_EVT, 32'h8000_0000, 32'h4000_0000, 1'b1, 5'd1,  4'd3},  // R3 clear one
        '{32'h0000_0003, 1'b1, OFS_SNA, 32'h0400_0000, 32'h4000_0000, 1'b1, 5'd1,  4'd8},  // R8 pin2 rise
        '{32'h0000_0007, 1'b0, OFS_EVT, 32'h0,         32'h6000_0000, 1'b1, 5'd1,  4'd8},  // R8 rise seen
        '{32'h0000_0003, 1'b1, OFS_EVT, 32'h2000_0000, 32'h4000_0000, 1'b1, 5'd1,  4'd8},  // R8 fall ignored
        '{32'h0010_0003, 1'b1, OFS_SNB, 32'h0080_0000, 32'h4000_0800, 1'b1, 5'd1,  4'd12}, // R12 old sense
        '{32'h0000_0003, 1'b1, OFS_EVT, 32'hFFFF_FFFF, 32'h0000_0800, 1'b1, 5'd20, 4'd4},  // R4 set wins
        '{32'h0000_0003, 1'b1, OFS_EVT, 32'hFFFF_FFFF, 32'h0000_0000, 1'b0, 5'd0,  4'd3},  // R3 clear all
        '{32'h0000_0003, 1'b1, OFS_SNA, 32'h0700_0000, 32'h0000_0000, 1'b0, 5'd0,  4'd9},  // R9 pin3 = 11
        '{32'h0000_000B, 1'b0, OFS_EVT, 32'h0,         32'h0000_0000, 1'b0, 5'd0,  4'd9},  // R9 rise
        '{32'h0000_0003, 1'b0, OFS_EVT, 32'h0,         32'h0000_0000, 1'b0, 5'd0,  4'd9},  // R9 fall
        '{32'h8000_0003, 1'b1, OFS_MSK, 32'h0,         32'h0000_0001, 1'b0, 5'd0,  4'd5},  // R5 masked latch
        '{32'h8000_0003, 1'b1, OFS_MSK, 32'h0000_0001, 32'h0000_0001, 1'b1, 5'd31, 4'd5},  // R5 enable
        '{32'h8000_0003, 1'b1, OFS_EVT, 32'h0,         32'h0000_0001, 1'b1, 5'd31, 4'd3}   // R3 zeros keep
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] pin_lvl = '0;
    logic        wr_x = 1'b0, wr_b = 1'b0;
    logic [7:0]  bus_addr = OFS_EVT;
    logic [31:0] bus_wdata = '0;
    logic [31:0] rd_x, rd_b;
    logic        irq_x, irq_b, val_x, val_b;
    logic [4:0]  id_x, id_b;

    int n_tests = 0;
    int n_fail  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_evt_sense #(.NPINS(32), .EXT_MODE(1'b1)) u_gpio_evt_sense (
        .clk(clk), .rst_n(rst_n), .pin_lvl(pin_lvl), .bus_wr(wr_x),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rd_x),
        .irq_out(irq_x), .irq_pin_valid(val_x), .irq_pin_id(id_x));

    gpio_evt_sense #(.NPINS(32), .EXT_MODE(1'b0)) u_basic (
        .clk(clk), .rst_n(rst_n), .pin_lvl(pin_lvl), .bus_wr(wr_b),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rd_b),
        .irq_out(irq_b), .irq_pin_valid(val_b), .irq_pin_id(id_b));

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // Called just after a falling edge; returns just after the next one.
    task automatic step(input bit sel, input logic [31:0] pins, input bit wr,
                        input logic [7:0] addr, input logic [31:0] wdata,
                        output logic [31:0] evt);
        pin_lvl   = pins;
        bus_addr  = addr;
        bus_wdata = wdata;
        wr_x      = wr & ~sel;
        wr_b      = wr & sel;
        @(posedge clk);
        @(negedge clk);
        wr_x     = 1'b0;
        wr_b     = 1'b0;
        bus_addr = OFS_EVT;
        #1;
        evt = sel ? rd_b : rd_x;
    endtask

    task automatic rd(input bit sel, input logic [7:0] addr, output logic [31:0] val);
        bus_addr = addr;
        #1;
        val = sel ? rd_b : rd_x;
    endtask

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] v;

        // R1: reset state, read while still in reset.
        repeat (3) @(negedge clk);
        #1;
        foreach (TBL[i]) begin end
        rd(1'b0, OFS_EVT, v); chk("R1 evt", v, 32'h0);
        rd(1'b0, OFS_MSK, v); chk("R1 mask", v, 32'h0);
        rd(1'b0, OFS_SNA, v); chk("R1 senseA", v, 32'h0);
        rd(1'b0, OFS_SNB, v); chk("R1 senseB", v, 32'h0);
        chk("R1 irq", {30'd0, irq_x, val_x}, 32'h0);
        rst_n = 1'b1;
        step(1'b0, 32'h0, 1'b0, OFS_EVT, 32'h0, v);   // priming clock
        chk("R1 evt after prime", v, 32'h0);

        // Table walk on the extended instance.
        for (int i = 0; i < NVEC; i++) begin
            step(1'b0, TBL[i].pins, TBL[i].wr, TBL[i].addr, TBL[i].wdata, v);
            n_tests++;
            if (v !== TBL[i].exp_evt || irq_x !== TBL[i].exp_irq || val_x !== TBL[i].exp_irq
                || (TBL[i].exp_irq && id_x !== TBL[i].exp_id)) begin
                n_fail++;
                $display("FAIL R%0d row %0d: got evt %h irq %b id %0d expected evt %h irq %b id %0d",
                         TBL[i].req, i, v, irq_x, id_x, TBL[i].exp_evt, TBL[i].exp_irq, TBL[i].exp_id);
            end
        end

        // R2: register map of the extended instance and unmapped offsets.
        step(1'b0, 32'h8000_0003, 1'b1, 8'h04, 32'hFFFF_FFFF, v);
        rd(1'b0, OFS_SNA, v); chk("R2 senseA", v, 32'h0700_0000);
        rd(1'b0, OFS_SNB, v); chk("R2 senseB", v, 32'h0080_0000);
        rd(1'b0, OFS_MSK, v); chk("R2 mask", v, 32'h0000_0001);
        rd(1'b0, 8'h04, v);   chk("R2 unmapped 04", v, 32'h0);
        rd(1'b0, 8'h1C, v);   chk("R2 unmapped 1C", v, 32'h0);

        // Basic-mode instance: clear what the shared pins produced.
        step(1'b1, 32'h8000_0003, 1'b1, OFS_EVT, 32'hFFFF_FFFF, v);
        chk("R3 basic clear", v, 32'h0);
        step(1'b1, 32'h8000_0003, 1'b1, OFS_SNA, 32'h8000_0000, v);
        chk("R7 setup", v, 32'h0);
        step(1'b1, 32'h8000_0002, 1'b0, OFS_EVT, 32'h0, v);
        chk("R7 pin0 fall", v, 32'h8000_0000);
        step(1'b1, 32'h8000_0003, 1'b0, OFS_EVT, 32'h0, v);
        chk("R7 pin0 rise ignored", v, 32'h8000_0000);
        step(1'b1, 32'h8000_0001, 1'b0, OFS_EVT, 32'h0, v);
        chk("R7 pin1 fall both", v, 32'hC000_0000);
        step(1'b1, 32'h8000_0003, 1'b1, OFS_EVT, 32'hC000_0000, v);
        chk("R7 pin1 rise both with R4 clear", v, 32'h4000_0000);
        chk("R5 basic masked irq", {31'd0, irq_b}, 32'h0);
        step(1'b1, 32'h8000_0003, 1'b1, OFS_SNB, 32'hFFFF_FFFF, v);
        rd(1'b1, OFS_SNB, v); chk("R10 senseB basic", v, 32'h0);
        rd(1'b1, OFS_SNA, v); chk("R2 senseA basic", v, 32'h8000_0000);

        // R11: reset with all pins high, no false edges after release.
        pin_lvl = 32'hFFFF_FFFF;
        rst_n   = 1'b0;
        repeat (2) @(negedge clk);
        #1;
        rd(1'b0, OFS_EVT, v); chk("R1 evt in second reset", v, 32'h0);
        rst_n = 1'b1;
        step(1'b0, 32'hFFFF_FFFF, 1'b0, OFS_EVT, 32'h0, v);
        chk("R11 prime clock ext", v, 32'h0);
        rd(1'b1, OFS_EVT, v); chk("R11 prime clock basic", v, 32'h0);
        step(1'b0, 32'hFFFF_FFFF, 1'b0, OFS_EVT, 32'h0, v);
        chk("R11 steady ext", v, 32'h0);
        step(1'b0, 32'h0, 1'b0, OFS_EVT, 32'h0, v);
        chk("R12 all fall ext", v, 32'hFFFF_FFFF);
        chk("R5 irq masked after reset", {31'd0, irq_x}, 32'h0);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule